// File: doc/BRIEF.md
# Page-Wrapping Word Address Counter

This block keeps the word-address pointer of a serial byte-wide memory. Its width follows the array size: 7 to 11 bits for 128 to 2048 bytes. A protocol front end loads it with the page-select bits joined to the received address byte. It pulses an increment strobe after each byte that is moved, and it tells the counter whether the current transfer is a read or a write.

Read increments step through the whole array and return from the top byte to byte zero. Write increments are confined to one 16-byte page: only the four low bits count, so the upper bits stay fixed, and stepping past the last byte of the page lands on the first byte of that page. The pointer holds its value between transfers. A later read that supplies no address therefore starts at the byte after the last one accessed.

Top module: `word_ptr`

## Requirements
- R1: While `rst_n` is low the pointer is zero, and it is still zero on the first clock after release.
- R2: When `ld` is high on a rising clock edge, `addr` equals `ld_addr` after that edge.
- R3: When `ld` and `inc` are both high in the same cycle, the load wins and the increment is dropped.
- R4: When `inc` is high with `rd_mode` = 0 (write), the low 4 bits of `addr` go up by one and bits [ADDR_W-1:4] do not change.
- R5: A write increment from a page's last byte (low 4 bits 0xF) gives the first byte of the same page (low 4 bits 0x0), with no carry into the upper bits. This includes the top page.
- R6: When `inc` is high with `rd_mode` = 1 (read), `addr` goes up by one across the full width and carries into the page bits.
- R7: A read increment from the top address (all ones) gives address zero.
- R8: When neither `ld` nor `inc` is high, `addr` holds its value whatever `rd_mode` and `ld_addr` carry, so a later current-address read continues from the stored pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld | input | 1 | Load strobe for the pointer |
| ld_addr | input | ADDR_W | Value to load (page bits joined to the address byte) |
| inc | input | 1 | Advance strobe, one pulse per byte transferred |
| rd_mode | input | 1 | 1 = read transfer (wraps over the full array), 0 = write (wraps within the page) |
| addr | output | ADDR_W | Current word address |

## Verification
A load and an increment can arrive in the same cycle. This happens when a front end reloads the pointer while the advance for the previous byte is still pending. The bench raises both strobes together in read mode and in write mode. It expects the loaded value with no step added, and it then checks that the next plain increment starts from the loaded value. The wrap corners are also exercised: a write from 0x7FF must give 0x7F0, and a read from 0x7FF must give 0x000.

// File: rtl/word_ptr.sv
module word_ptr #(
  parameter int DEPTH  = 2048,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              inc,
  input  logic              rd_mode,
  output logic [ADDR_W-1:0] addr
);
  localparam int PG = 4;

  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] step_rd;
  logic [ADDR_W-1:0] step_wr;

  assign step_rd = ptr_q + ADDR_W'(1);
  assign step_wr = {ptr_q[ADDR_W-1:PG], ptr_q[PG-1:0] + PG'(1)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (ld)  ptr_q <= ld_addr;
    else if (inc) ptr_q <= rd_mode ? step_rd : step_wr;
  end

  assign addr = ptr_q;
endmodule

// File: rtl/word_ptr_chk.sv
module word_ptr_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld,
  input logic [ADDR_W-1:0] ld_addr,
  input logic              inc,
  input logic              rd_mode,
  input logic [ADDR_W-1:0] addr
);
  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> addr == '0);  // R1
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> addr == $past(ld_addr));  // R2
  AST_LOAD_OVER_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && inc) |=> addr == $past(ld_addr));  // R3
  AST_WR_UPPER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld && !rd_mode) |=> addr[ADDR_W-1:4] == $past(addr[ADDR_W-1:4]));  // R4
  AST_WR_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld && !rd_mode && addr[3:0] == 4'hF) |=> addr[3:0] == 4'h0);  // R5
  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld && rd_mode) |=> addr == $past(addr) + ADDR_W'(1));  // R6
  AST_RD_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld && rd_mode && (&addr)) |=> addr == '0);  // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !inc) |=> $stable(addr));  // R8
endmodule

bind word_ptr word_ptr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld(ld), .ld_addr(ld_addr),
  .inc(inc), .rd_mode(rd_mode), .addr(addr)
);

// File: tb/tb_word_ptr.sv
`timescale 1ns/1ps
module tb_word_ptr;
  localparam int DEPTH = 2048;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0, ld = 0, inc = 0, rd_mode = 0;
  logic [AW-1:0] ld_addr = '0;
  logic [AW-1:0] addr;

  typedef struct { logic [AW-1:0] exp; string req; } item_t;
  item_t q[$];
  logic [AW-1:0] model = '0;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  word_ptr #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_addr(ld_addr),
    .inc(inc), .rd_mode(rd_mode), .addr(addr)
  );

  task automatic check(logic [AW-1:0] exp, string req);
    n_chk++;
    if (addr !== exp) begin
      n_fail++;
      $display("FAIL %s: addr=%h expected=%h", req, addr, exp);
    end
  endtask

  task automatic drive(bit l, logic [AW-1:0] v, bit i, bit r, string req);
    item_t it;
    @(negedge clk);
    ld = l; ld_addr = v; inc = i; rd_mode = r;
    if (l) model = v;
    else if (i && r) model = model + 1'b1;
    else if (i) model = {model[AW-1:4], 4'(model[3:0] + 4'd1)};
    it.exp = model; it.req = req;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(it.exp, it.req);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: addr=%h expected=done", addr);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check('0, "R1 during reset");
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1 check('0, "R1 after release");

    drive(1, 11'h123, 0, 0, "R2 load");
    drive(0, 11'h000, 1, 0, "R4 write step");
    drive(0, 11'h000, 1, 0, "R4 write step");
    drive(0, 11'h000, 1, 0, "R4 write step");
    drive(1, 11'h13E, 0, 1, "R2 load");
    drive(0, 11'h000, 1, 0, "R4 write to page end");
    drive(0, 11'h000, 1, 0, "R5 write page wrap 13F->130");
    drive(0, 11'h000, 1, 0, "R4 step after wrap");
    drive(0, 11'h5A5, 0, 1, "R8 hold rd_mode=1");
    drive(0, 11'h2AA, 0, 0, "R8 hold rd_mode=0");
    drive(0, 11'h000, 1, 1, "R8 current read resumes, R6 step");
    drive(1, 11'h0FF, 0, 1, "R2 load");
    drive(0, 11'h000, 1, 1, "R6 read carry into page bits");
    drive(1, 11'h7FE, 0, 0, "R2 load");
    drive(0, 11'h000, 1, 1, "R6 read step");
    drive(0, 11'h000, 1, 1, "R7 read rollover 7FF->000");
    drive(1, 11'h7FF, 0, 0, "R2 load");
    drive(0, 11'h000, 1, 0, "R5 top page wrap 7FF->7F0");
    drive(1, 11'h055, 1, 1, "R3 load beats read inc");
    drive(0, 11'h000, 1, 1, "R3 step from loaded value");
    drive(1, 11'h3AF, 1, 0, "R3 load beats write inc");
    drive(0, 11'h000, 1, 0, "R5 wrap from loaded 3AF");
    drive(0, 11'h000, 0, 0, "R8 idle hold");
    drive(0, 11'h000, 0, 1, "R8 idle hold");
    @(negedge clk); ld = 0; inc = 0;
    repeat (3) @(posedge clk);
    #2 finish_run();
  end
endmodule